// File: doc/BRIEF.md
# Thread-Tagged Translation Buffer with Scoped Invalidation

This block is a small, fully associative translation buffer shared by two hardware threads. Each entry maps a virtual page to a physical page. It also records a global flag and the ID of the thread whose fill created it. A lookup can only hit entries owned by the requesting thread. This holds even for entries flagged global, so the global flag never makes an entry visible across threads.

Three invalidation kinds are provided: an address-space switch, a paging-control flush and a single-page drop. Each one is confined to the issuing thread's entries and never disturbs the other thread's translations. An invalidate acts in the cycle it is presented, and a lookup in that same cycle already sees its effect. Lookup results are registered and appear one clock after the request. Fills allocate slots in round-robin order, unless the same thread already holds the same page, in which case that entry is rewritten in place.

Top module: `tt_tlb`

## Requirements
- R1: After reset no entry is valid: `rs_valid` and `rs_hit` read 0, and a lookup of any page misses until a fill is made.
- R2: A lookup presented on the edge where `lk_valid` is 1 produces, on the next edge, `rs_valid`=1 and `rs_hit`=1 exactly when a valid entry has the same thread ID and virtual page, together with that entry's physical page and global flag.
- R3: An entry with the global flag set still hits only for the thread that filled it.
- R4: Invalidate kind 0 (`iv_kind`=2'b00, address-space switch) removes the issuing thread's non-global entries and keeps its global ones.
- R5: Invalidate kind 1 (`iv_kind`=2'b01, paging-control flush) removes every entry of the issuing thread, global or not.
- R6: Invalidate kind 2 (`iv_kind`=2'b10, single page) removes the issuing thread's entry for `iv_vpn`, whether or not it is global.
- R7: No invalidate kind removes or alters an entry owned by the other thread.
- R8: A lookup presented in the same cycle as an invalidate sees the state after the invalidate. A fill presented in the same cycle as a lookup is not yet visible to that lookup.
- R9: A fill whose thread ID and virtual page match a valid entry overwrites that entry in place, does not consume a replacement slot, and never leaves two entries with the same thread and page.
- R10: Fills that allocate take slots 0, 1, 2, … in order and wrap after the last slot, whether or not the slot was free. With 16 entries, the 17th allocating fill evicts the first one.
- R11: Invalidate code 3 (`iv_kind`=2'b11) has no effect on any entry.
- R12: When `rs_hit` is 0, `rs_ppn` and `rs_glob` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request |
| lk_tid | input | TID_W | Requesting thread ID |
| lk_vpn | input | VPN_W | Virtual page to translate |
| fl_valid | input | 1 | Fill request |
| fl_tid | input | TID_W | Filling thread ID |
| fl_vpn | input | VPN_W | Virtual page of the fill |
| fl_ppn | input | PPN_W | Physical page of the fill |
| fl_glob | input | 1 | Global flag of the fill |
| iv_valid | input | 1 | Invalidate request |
| iv_kind | input | 2 | 0 space switch, 1 full flush, 2 single page, 3 no-op |
| iv_tid | input | TID_W | Issuing thread ID |
| iv_vpn | input | VPN_W | Page for single-page invalidate |
| rs_valid | output | 1 | Registered: a lookup was presented last cycle |
| rs_hit | output | 1 | Registered hit |
| rs_ppn | output | PPN_W | Registered physical page, 0 on miss |
| rs_glob | output | 1 | Registered global flag, 0 on miss |

## Verification
Two situations are hard to reach from the ports. The first is replacement wrap-around: to get there, the stimulus fills one page twice and then fills fifteen more distinct pages. Every one of the sixteen distinct pages must still hit. The next allocating fill must then evict exactly the first page, which exposes both a pointer that advanced on an in-place overwrite and a pointer that failed to wrap. The second is same-cycle interaction, which the vector table reaches by placing an invalidate and a lookup of the affected page in one cycle, and a fill with a lookup of the same page in one cycle. Between the invalidates, the table looks up the other thread's pages to show they survive.

// File: rtl/tt_tlb_pkg.sv
package tt_tlb_pkg;

  // Invalidate command encoding seen on iv_kind
  typedef enum logic [1:0] {
    INV_SPACE = 2'd0,  // drop own non-global entries
    INV_ALL   = 2'd1,  // drop all own entries
    INV_PAGE  = 2'd2,  // drop own entry for one page
    INV_NOP   = 2'd3   // reserved, no effect
  } inv_kind_e;

endpackage

// File: rtl/tt_tlb_match.sv
module tt_tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int TID_W   = 1
) (
  input  logic [ENTRIES-1:0]            live,
  input  logic [ENTRIES-1:0][TID_W-1:0] ent_tid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
  input  logic [TID_W-1:0]              q_tid,
  input  logic [VPN_W-1:0]              q_vpn,
  output logic [ENTRIES-1:0]            mvec
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign mvec[i] = live[i] && (ent_tid[i] == q_tid) && (ent_vpn[i] == q_vpn);
  end

endmodule

// File: rtl/tt_tlb_rr.sv
module tt_tlb_rr #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/tt_tlb_store.sv
module tt_tlb_store #(
  parameter  int ENTRIES = 16,
  parameter  int VPN_W   = 20,
  parameter  int PPN_W   = 20,
  parameter  int TID_W   = 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            kill,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TID_W-1:0]              wr_tid,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  logic                          wr_glob,
  output logic [ENTRIES-1:0]            ent_vld,
  output logic [ENTRIES-1:0]            ent_glob,
  output logic [ENTRIES-1:0][TID_W-1:0] ent_tid,
  output logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
  output logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn
);

  logic [ENTRIES-1:0] vld_q, vld_d, we;

  // valid bits: invalidate first, then the fill lands on top
  always_comb begin
    vld_d = vld_q & ~kill;
    we    = '0;
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
      we[wr_idx]    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload: enable-gated, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (we[i]) begin
        ent_tid[i]  <= wr_tid;
        ent_vpn[i]  <= wr_vpn;
        ent_ppn[i]  <= wr_ppn;
        ent_glob[i] <= wr_glob;
      end
    end
  end

  assign ent_vld = vld_q;

endmodule

// File: rtl/tt_tlb.sv
module tt_tlb #(
  parameter  int ENTRIES = 16,
  parameter  int THREADS = 2,
  parameter  int VPN_W   = 20,
  parameter  int PPN_W   = 20,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [TID_W-1:0] lk_tid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fl_valid,
  input  logic [TID_W-1:0] fl_tid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PPN_W-1:0] fl_ppn,
  input  logic             fl_glob,
  input  logic             iv_valid,
  input  logic [1:0]       iv_kind,
  input  logic [TID_W-1:0] iv_tid,
  input  logic [VPN_W-1:0] iv_vpn,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic [PPN_W-1:0] rs_ppn,
  output logic             rs_glob
);
  import tt_tlb_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // entry state
  logic [ENTRIES-1:0]            ent_vld, ent_glob;
  logic [ENTRIES-1:0][TID_W-1:0] ent_tid;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;

  // invalidate: computed from current state, applied this cycle
  inv_kind_e          kind;
  logic [ENTRIES-1:0] pg_mvec, kill, live;

  assign kind = inv_kind_e'(iv_kind);

  tt_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TID_W(TID_W)) u_pg_match (
    .live    (ent_vld),
    .ent_tid (ent_tid),
    .ent_vpn (ent_vpn),
    .q_tid   (iv_tid),
    .q_vpn   (iv_vpn),
    .mvec    (pg_mvec)
  );

  always_comb begin
    kill = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      logic own;
      own = ent_vld[i] && (ent_tid[i] == iv_tid);
      if (iv_valid) begin
        case (kind)
          INV_SPACE: kill[i] = own && !ent_glob[i];
          INV_ALL:   kill[i] = own;
          INV_PAGE:  kill[i] = pg_mvec[i];
          default:   kill[i] = 1'b0;
        endcase
      end
    end
  end

  assign live = ent_vld & ~kill;

  // lookup against post-invalidate state
  logic [ENTRIES-1:0] lk_mvec;
  logic [PPN_W-1:0]   lk_ppn;
  logic               lk_glob, lk_hit;

  tt_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TID_W(TID_W)) u_lk_match (
    .live    (live),
    .ent_tid (ent_tid),
    .ent_vpn (ent_vpn),
    .q_tid   (lk_tid),
    .q_vpn   (lk_vpn),
    .mvec    (lk_mvec)
  );

  always_comb begin
    lk_ppn  = '0;
    lk_glob = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_mvec[i]) begin
        lk_ppn  = lk_ppn | ent_ppn[i];
        lk_glob = lk_glob | ent_glob[i];
      end
    end
  end

  assign lk_hit = lk_valid && (|lk_mvec);

  // fill: overwrite a matching entry, else take the round-robin slot
  logic [ENTRIES-1:0] fl_mvec;
  logic [IDX_W-1:0]   fl_hit_idx, rr_ptr, wr_idx;
  logic               fl_hit;

  tt_tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .TID_W(TID_W)) u_fl_match (
    .live    (live),
    .ent_tid (ent_tid),
    .ent_vpn (ent_vpn),
    .q_tid   (fl_tid),
    .q_vpn   (fl_vpn),
    .mvec    (fl_mvec)
  );

  always_comb begin
    fl_hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fl_mvec[i]) fl_hit_idx = IDX_W'(i);
    end
  end

  assign fl_hit = |fl_mvec;
  assign wr_idx = fl_hit ? fl_hit_idx : rr_ptr;

  tt_tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (fl_valid && !fl_hit),
    .ptr   (rr_ptr)
  );

  tt_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .TID_W(TID_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .kill     (kill),
    .wr_en    (fl_valid),
    .wr_idx   (wr_idx),
    .wr_tid   (fl_tid),
    .wr_vpn   (fl_vpn),
    .wr_ppn   (fl_ppn),
    .wr_glob  (fl_glob),
    .ent_vld  (ent_vld),
    .ent_glob (ent_glob),
    .ent_tid  (ent_tid),
    .ent_vpn  (ent_vpn),
    .ent_ppn  (ent_ppn)
  );

  // registered result
  logic             rs_valid_d, rs_hit_d, rs_glob_d;
  logic [PPN_W-1:0] rs_ppn_d;

  always_comb begin
    rs_valid_d = lk_valid;
    rs_hit_d   = lk_hit;
    rs_ppn_d   = lk_hit ? lk_ppn : '0;
    rs_glob_d  = lk_hit && lk_glob;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_ppn   <= '0;
      rs_glob  <= 1'b0;
    end else begin
      rs_valid <= rs_valid_d;
      rs_hit   <= rs_hit_d;
      rs_ppn   <= rs_ppn_d;
      rs_glob  <= rs_glob_d;
    end
  end

endmodule

// File: rtl/tt_tlb_chk.sv
module tt_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 20,
  parameter int TID_W   = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lk_valid,
  input logic                          fl_valid,
  input logic                          iv_valid,
  input logic [1:0]                    iv_kind,
  input logic [TID_W-1:0]              iv_tid,
  input logic                          rs_valid,
  input logic                          rs_hit,
  input logic [PPN_W-1:0]              rs_ppn,
  input logic                          rs_glob,
  input logic [ENTRIES-1:0]            ent_vld,
  input logic [ENTRIES-1:0]            ent_glob,
  input logic [ENTRIES-1:0][TID_W-1:0] ent_tid,
  input logic [ENTRIES-1:0]            lk_mvec
);

  assert_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> rs_valid);

  assert_result_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rs_valid == $past(lk_valid)));

  assert_miss_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_hit |-> (rs_ppn == '0 && !rs_glob));

  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_mvec));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assert_space_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && iv_kind == 2'd0 && !fl_valid && ent_vld[i] &&
       ent_tid[i] == iv_tid && !ent_glob[i]) |=> !ent_vld[i]);

    assert_space_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && iv_kind == 2'd0 && ent_vld[i] && ent_glob[i]) |=> ent_vld[i]);

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && iv_kind == 2'd1 && !fl_valid && ent_vld[i] &&
       ent_tid[i] == iv_tid) |=> !ent_vld[i]);

    assert_other_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && ent_vld[i] && ent_tid[i] != iv_tid) |=> ent_vld[i]);

    assert_nop_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && iv_kind == 2'd3 && ent_vld[i]) |=> ent_vld[i]);
  end

endmodule

bind tt_tlb tt_tlb_chk #(
  .ENTRIES(ENTRIES), .PPN_W(PPN_W), .TID_W(TID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .lk_valid (lk_valid),
  .fl_valid (fl_valid),
  .iv_valid (iv_valid),
  .iv_kind  (iv_kind),
  .iv_tid   (iv_tid),
  .rs_valid (rs_valid),
  .rs_hit   (rs_hit),
  .rs_ppn   (rs_ppn),
  .rs_glob  (rs_glob),
  .ent_vld  (ent_vld),
  .ent_glob (ent_glob),
  .ent_tid  (ent_tid),
  .lk_mvec  (lk_mvec)
);

// File: tb/tt_tlb_bench.sv
module tt_tlb_bench;

  localparam int VW = 20;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0, fl_valid = 1'b0, iv_valid = 1'b0;
  logic [0:0]    lk_tid = '0, fl_tid = '0, iv_tid = '0;
  logic [VW-1:0] lk_vpn = '0, fl_vpn = '0, iv_vpn = '0;
  logic [PW-1:0] fl_ppn = '0;
  logic          fl_glob = 1'b0;
  logic [1:0]    iv_kind = 2'd0;
  logic          rs_valid, rs_hit, rs_glob;
  logic [PW-1:0] rs_ppn;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tt_tlb u_tt_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_vpn(lk_vpn),
    .fl_valid(fl_valid), .fl_tid(fl_tid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_glob(fl_glob),
    .iv_valid(iv_valid), .iv_kind(iv_kind), .iv_tid(iv_tid), .iv_vpn(iv_vpn),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_ppn(rs_ppn), .rs_glob(rs_glob)
  );

  typedef struct packed {
    logic          fv;  logic fl_t; logic [VW-1:0] fvpn; logic [PW-1:0] fppn; logic fg;
    logic          iv;  logic [1:0] ik; logic iv_t; logic [VW-1:0] ivpn;
    logic          lv;  logic lk_t; logic [VW-1:0] lvpn;
    logic          eh;  logic [PW-1:0] eppn; logic eg;
    int            rq;
  } vec_t;

  function automatic vec_t v(logic fv, logic ft, int fvpn, int fppn, logic fg,
                             logic iv, int ik, logic it, int ivpn,
                             logic lv, logic lt, int lvpn,
                             logic eh, int eppn, logic eg, int rq);
    vec_t r;
    r.fv = fv; r.fl_t = ft; r.fvpn = VW'(fvpn); r.fppn = PW'(fppn); r.fg = fg;
    r.iv = iv; r.ik = 2'(ik); r.iv_t = it; r.ivpn = VW'(ivpn);
    r.lv = lv; r.lk_t = lt; r.lvpn = VW'(lvpn);
    r.eh = eh; r.eppn = PW'(eppn); r.eg = eg; r.rq = rq;
    return r;
  endfunction

  localparam int NV = 18;
  // fill(v,t,vpn,ppn,g) inval(v,kind,t,vpn) look(v,t,vpn) expect(hit,ppn,g) req
  localparam vec_t TBL [NV] = '{
    v(1,0,'h10,'hA1,0, 0,0,0,0,     1,0,'h10, 0,0,0,     8),  // R8 fill not yet seen
    v(0,0,0,0,0,       0,0,0,0,     1,0,'h10, 1,'hA1,0,  2),  // R2
    v(0,0,0,0,0,       0,0,0,0,     1,1,'h10, 0,0,0,     2),  // R2 other thread
    v(1,0,'h20,'hB2,1, 0,0,0,0,     0,0,0,    0,0,0,     2),
    v(0,0,0,0,0,       0,0,0,0,     1,1,'h20, 0,0,0,     3),  // R3 global stays private
    v(0,0,0,0,0,       0,0,0,0,     1,0,'h20, 1,'hB2,1,  3),
    v(1,1,'h10,'hC3,0, 0,0,0,0,     0,0,0,    0,0,0,     2),
    v(1,1,'h30,'hD4,1, 0,0,0,0,     1,1,'h10, 1,'hC3,0,  2),
    v(0,0,0,0,0,       1,0,0,0,     1,0,'h10, 0,0,0,     4),  // R4 + R8 same cycle
    v(0,0,0,0,0,       0,0,0,0,     1,0,'h20, 1,'hB2,1,  4),  // R4 global kept
    v(0,0,0,0,0,       0,0,0,0,     1,1,'h10, 1,'hC3,0,  7),  // R7
    v(0,0,0,0,0,       1,2,1,'h30,  1,1,'h30, 0,0,0,     6),  // R6 global page dropped
    v(0,0,0,0,0,       0,0,0,0,     1,1,'h10, 1,'hC3,0,  6),
    v(0,0,0,0,0,       1,3,0,0,     1,0,'h20, 1,'hB2,1,  11), // R11
    v(0,0,0,0,0,       1,1,0,0,     1,0,'h20, 0,0,0,     5),  // R5
    v(0,0,0,0,0,       0,0,0,0,     1,1,'h10, 1,'hC3,0,  7),  // R7 after full flush
    v(1,1,'h10,'hE5,1, 0,0,0,0,     0,0,0,    0,0,0,     9),
    v(0,0,0,0,0,       0,0,0,0,     1,1,'h10, 1,'hE5,1,  9)   // R9 overwrite
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fl_valid = 0; iv_valid = 0;
  endtask

  // drive at a falling edge; outputs valid at the next falling edge
  task automatic do_fill(input logic t, input int vpn, input int ppn, input logic g);
    fl_valid = 1; fl_tid = t; fl_vpn = VW'(vpn); fl_ppn = PW'(ppn); fl_glob = g;
    @(negedge clk);
    idle();
  endtask

  task automatic do_look(input logic t, input int vpn, input logic eh,
                         input int eppn, input logic eg, input int rq);
    lk_valid = 1; lk_tid = t; lk_vpn = VW'(vpn);
    @(negedge clk);
    idle();
    check(rs_valid == 1'b1, rq, "rs_valid", rs_valid, 1);
    check(rs_hit == eh, rq, $sformatf("hit vpn %0h", vpn), rs_hit, eh);
    check(rs_ppn == PW'(eppn) && rs_glob == eg, rq, $sformatf("ppn/glob vpn %0h", vpn),
          {rs_ppn, rs_glob}, {PW'(eppn), eg});
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check(rs_valid == 0 && rs_hit == 0, 1, "outputs after reset", {rs_valid, rs_hit}, 0);
    do_look(0, 'h10, 0, 0, 0, 1);

    // vector table, one cycle each
    for (int n = 0; n < NV; n++) begin
      fl_valid = TBL[n].fv; fl_tid = TBL[n].fl_t; fl_vpn = TBL[n].fvpn;
      fl_ppn = TBL[n].fppn; fl_glob = TBL[n].fg;
      iv_valid = TBL[n].iv; iv_kind = TBL[n].ik; iv_tid = TBL[n].iv_t; iv_vpn = TBL[n].ivpn;
      lk_valid = TBL[n].lv; lk_tid = TBL[n].lk_t; lk_vpn = TBL[n].lvpn;
      @(negedge clk);
      idle();
      check(rs_valid == TBL[n].lv, TBL[n].rq, $sformatf("vec %0d valid", n),
            rs_valid, TBL[n].lv);
      check(rs_hit == TBL[n].eh, TBL[n].rq, $sformatf("vec %0d hit", n),
            rs_hit, TBL[n].eh);
      check(rs_ppn == TBL[n].eppn && rs_glob == TBL[n].eg, TBL[n].rq,
            $sformatf("vec %0d ppn/glob (R12 on miss)", n),
            {rs_ppn, rs_glob}, {TBL[n].eppn, TBL[n].eg});
    end

    // R1: reset clears entries filled earlier
    do_reset();
    do_look(1, 'h10, 0, 0, 0, 1);

    // R9/R10: overwrite must not consume a slot; then wrap evicts slot 0
    do_fill(0, 'h100, 'h500, 0);
    do_fill(0, 'h100, 'h600, 0);
    for (int k = 1; k < 16; k++) do_fill(0, 'h100 + k, 'h700 + k, 0);
    do_look(0, 'h100, 1, 'h600, 0, 9);
    for (int k = 1; k < 16; k++) do_look(0, 'h100 + k, 1, 'h700 + k, 0, 10);
    do_fill(0, 'h200, 'h800, 1);
    do_look(0, 'h100, 0, 0, 0, 10);   // R10 first entry evicted
    do_look(0, 'h101, 1, 'h701, 0, 10);
    do_look(0, 'h200, 1, 'h800, 1, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule